// File: doc/BRIEF.md
# Virtual Circuit Label Swap Table

This block holds the connection state of one switch that forwards by virtual circuit. Every arriving packet header presents the port it came in on and its circuit identifier (VCI). The block searches all stored circuits for that pair at once. On a hit it returns the output port and the new VCI that replaces the old one in the forwarded header. The label therefore changes at every hop.

A packet whose pair is not stored is flagged as a miss and is not forwarded. Circuits are installed and removed through a configuration port that stands in for connection setup and teardown. A circuit has to be installed before its data can pass. Two inputs may use the same VCI value without conflict, because the key is always the pair. Setting up a key that already exists overwrites that circuit. Setting up a new key when every slot is in use is refused with an error pulse.

Top module: `vcx_label_swap`

## Requirements
- R1: After reset no circuit is stored, every output is low, and every packet misses until a circuit is installed.
- R2: A packet presented with pkt_valid high produces, on the next cycle, fwd_valid high with fwd_port and fwd_vci taken from the circuit whose (input port, VCI) key equals the packet's pair.
- R3: Keys that share a VCI value but differ in input port are distinct circuits, each with its own result.
- R4: A packet whose pair matches no stored circuit gives fwd_valid and fwd_miss high on the next cycle, with fwd_port and fwd_vci both zero.
- R5: A setup (cfg_op = 0) for a key already stored replaces that circuit's result, uses no further slot and raises no error, even when the table is full.
- R6: A teardown (cfg_op = 1) removes the circuit with the given key so that later packets with that pair miss. A teardown of an absent key changes nothing.
- R7: A setup for a new key while all DEPTH slots are in use raises cfg_err for exactly the next cycle and leaves the table unchanged.
- R8: DEPTH circuits can be stored at once, and a slot freed by teardown can be reused by a later setup.
- R9: A packet presented in the same cycle as a configuration command is looked up in the table as it stood before that command.
- R10: At no time does more than one stored circuit match a lookup key.
- R11: fwd_valid is high in a cycle exactly when pkt_valid was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration command present |
| cfg_op | input | 1 | 0 = setup, 1 = teardown |
| cfg_in_port | input | PORT_W | Input port of the circuit key |
| cfg_in_vci | input | VCI_W | Incoming VCI of the circuit key |
| cfg_out_port | input | PORT_W | Output port stored by setup |
| cfg_out_vci | input | VCI_W | Outgoing VCI stored by setup |
| cfg_err | output | 1 | Setup refused because the table is full |
| pkt_valid | input | 1 | Packet header present |
| pkt_in_port | input | PORT_W | Port the packet arrived on |
| pkt_in_vci | input | VCI_W | VCI carried by the packet |
| fwd_valid | output | 1 | Lookup result present |
| fwd_miss | output | 1 | No circuit matched; packet is dropped |
| fwd_port | output | PORT_W | Output port for the packet |
| fwd_vci | output | VCI_W | Rewritten VCI for the next hop |

## Verification
The checker watches on every cycle that at most one slot matches, that a result follows each packet by one cycle and never appears without one, that a miss carries zero fields, and that an error appears only after a refused setup with every slot occupied. Whether the right result comes back, whether an overwrite or a teardown takes effect, whether a same-cycle command stays hidden from a lookup, and whether a freed slot is reused can only be shown by the bench's scenarios. In those scenarios a behavioural key-to-result map predicts every output on every clock.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
   localparam logic OP_SETUP    = 1'b0;
   localparam logic OP_TEARDOWN = 1'b1;
endpackage

// File: rtl/vcx_entry.sv
module vcx_entry #(
   parameter int KEY_W = 6,
   parameter int RES_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [KEY_W-1:0] key_wr_i,
   input  logic [RES_W-1:0] res_wr_i,
   input  logic [KEY_W-1:0] lk_key_i,
   input  logic [KEY_W-1:0] cf_key_i,
   output logic             valid_o,
   output logic             lk_hit_o,
   output logic             cf_hit_o,
   output logic [RES_W-1:0] res_o
);
   logic [KEY_W-1:0] key_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         key_q   <= '0;
         res_o   <= '0;
      end else if (set_i) begin
         valid_o <= 1'b1;
         key_q   <= key_wr_i;
         res_o   <= res_wr_i;
      end else if (clr_i) begin
         valid_o <= 1'b0;
      end
   end

   assign lk_hit_o = valid_o && (key_q == lk_key_i);
   assign cf_hit_o = valid_o && (key_q == cf_key_i);
endmodule

// File: rtl/vcx_alloc.sv
module vcx_alloc #(
   parameter int DEPTH    = 16,
   parameter bit FROM_TOP = 1'b0
) (
   input  logic [DEPTH-1:0] free_i,
   output logic [DEPTH-1:0] sel_o,
   output logic             any_o
);
   assign any_o = |free_i;

   generate
      if (FROM_TOP) begin : g_high
         always_comb begin
            logic found;
            found = 1'b0;
            sel_o = '0;
            for (int i = DEPTH - 1; i >= 0; i--) begin
               if (!found && free_i[i]) begin
                  sel_o[i] = 1'b1;
                  found    = 1'b1;
               end
            end
         end
      end else begin : g_low
         always_comb begin
            logic found;
            found = 1'b0;
            sel_o = '0;
            for (int i = 0; i < DEPTH; i++) begin
               if (!found && free_i[i]) begin
                  sel_o[i] = 1'b1;
                  found    = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vcx_select.sv
module vcx_select #(
   parameter int DEPTH = 16,
   parameter int RES_W = 6
) (
   input  logic [DEPTH-1:0]            hit_i,
   input  logic [DEPTH-1:0][RES_W-1:0] res_i,
   output logic [RES_W-1:0]            res_o
);
   always_comb begin
      res_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         res_o = res_o | (res_i[i] & {RES_W{hit_i[i]}});
      end
   end
endmodule

// File: rtl/vcx_label_swap.sv
module vcx_label_swap #(
   parameter int PORT_W         = 2,
   parameter int VCI_W          = 4,
   parameter int DEPTH          = 16,
   parameter bit ALLOC_FROM_TOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic              cfg_op,
   input  logic [PORT_W-1:0] cfg_in_port,
   input  logic [VCI_W-1:0]  cfg_in_vci,
   input  logic [PORT_W-1:0] cfg_out_port,
   input  logic [VCI_W-1:0]  cfg_out_vci,
   output logic              cfg_err,
   input  logic              pkt_valid,
   input  logic [PORT_W-1:0] pkt_in_port,
   input  logic [VCI_W-1:0]  pkt_in_vci,
   output logic              fwd_valid,
   output logic              fwd_miss,
   output logic [PORT_W-1:0] fwd_port,
   output logic [VCI_W-1:0]  fwd_vci
);
   import vcx_pkg::*;

   localparam int KEY_W = PORT_W + VCI_W;
   localparam int RES_W = PORT_W + VCI_W;

   if (PORT_W < 1) begin : g_bad_port
      $error("vcx_label_swap: PORT_W must be at least 1");
   end
   if (VCI_W < 1) begin : g_bad_vci
      $error("vcx_label_swap: VCI_W must be at least 1");
   end
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("vcx_label_swap: DEPTH must lie in 2..256");
   end

   logic [KEY_W-1:0]            lk_key, cf_key;
   logic [RES_W-1:0]            cf_res, lk_res;
   logic [DEPTH-1:0]            valid_vec, lk_hit, cf_hit;
   logic [DEPTH-1:0]            set_vec, clr_vec, alloc_sel;
   logic [DEPTH-1:0][RES_W-1:0] res_arr;
   logic                        any_free, cf_exists;
   logic                        do_setup, do_tear, err_d, lk_found;

   assign lk_key = {pkt_in_port, pkt_in_vci};
   assign cf_key = {cfg_in_port, cfg_in_vci};
   assign cf_res = {cfg_out_port, cfg_out_vci};

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      vcx_entry #(.KEY_W(KEY_W), .RES_W(RES_W)) u_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (set_vec[g]),
         .clr_i    (clr_vec[g]),
         .key_wr_i (cf_key),
         .res_wr_i (cf_res),
         .lk_key_i (lk_key),
         .cf_key_i (cf_key),
         .valid_o  (valid_vec[g]),
         .lk_hit_o (lk_hit[g]),
         .cf_hit_o (cf_hit[g]),
         .res_o    (res_arr[g])
      );
   end

   vcx_alloc #(.DEPTH(DEPTH), .FROM_TOP(ALLOC_FROM_TOP)) u_alloc (
      .free_i (~valid_vec),
      .sel_o  (alloc_sel),
      .any_o  (any_free)
   );

   vcx_select #(.DEPTH(DEPTH), .RES_W(RES_W)) u_select (
      .hit_i (lk_hit),
      .res_i (res_arr),
      .res_o (lk_res)
   );

   assign cf_exists = |cf_hit;
   assign lk_found  = |lk_hit;
   assign do_setup  = cfg_valid && (cfg_op == OP_SETUP);
   assign do_tear   = cfg_valid && (cfg_op == OP_TEARDOWN);
   assign err_d     = do_setup && !cf_exists && !any_free;

   always_comb begin
      set_vec = '0;
      if (do_setup) set_vec = cf_exists ? cf_hit : alloc_sel;
      clr_vec = do_tear ? cf_hit : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_miss  <= 1'b0;
         fwd_port  <= '0;
         fwd_vci   <= '0;
         cfg_err   <= 1'b0;
      end else begin
         fwd_valid <= pkt_valid;
         fwd_miss  <= pkt_valid && !lk_found;
         {fwd_port, fwd_vci} <= pkt_valid ? lk_res : '0;
         cfg_err   <= err_d;
      end
   end
endmodule

// File: rtl/vcx_label_swap_chk.sv
module vcx_label_swap_chk #(
   parameter int PORT_W = 2,
   parameter int VCI_W  = 4,
   parameter int DEPTH  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_valid,
   input logic              cfg_op,
   input logic              pkt_valid,
   input logic              fwd_valid,
   input logic              fwd_miss,
   input logic [PORT_W-1:0] fwd_port,
   input logic [VCI_W-1:0]  fwd_vci,
   input logic              cfg_err,
   input logic [DEPTH-1:0]  lk_hit,
   input logic [DEPTH-1:0]  valid_vec
);
   assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit));

   assert_result_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> fwd_valid);

   assert_no_stray_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |=> !fwd_valid);

   assert_miss_fields_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_miss |-> (fwd_valid && fwd_port == '0 && fwd_vci == '0));

   assert_err_after_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_op == 1'b0 && !(&valid_vec)) |=> !cfg_err);

   assert_err_table_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (&valid_vec));

   assert_no_err_on_teardown_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_op == 1'b1) |=> !cfg_err);
endmodule

bind vcx_label_swap vcx_label_swap_chk #(.PORT_W(PORT_W), .VCI_W(VCI_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_valid (cfg_valid),
   .cfg_op    (cfg_op),
   .pkt_valid (pkt_valid),
   .fwd_valid (fwd_valid),
   .fwd_miss  (fwd_miss),
   .fwd_port  (fwd_port),
   .fwd_vci   (fwd_vci),
   .cfg_err   (cfg_err),
   .lk_hit    (lk_hit),
   .valid_vec (valid_vec)
);

// File: tb/vcx_label_swap_bench.sv
module vcx_label_swap_bench;
   localparam int PORT_W = 2;
   localparam int VCI_W  = 4;
   localparam int DEPTH  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_valid = 1'b0, cfg_op = 1'b0;
   logic [PORT_W-1:0] cfg_in_port = '0, cfg_out_port = '0;
   logic [VCI_W-1:0]  cfg_in_vci = '0, cfg_out_vci = '0;
   logic              cfg_err;
   logic              pkt_valid = 1'b0;
   logic [PORT_W-1:0] pkt_in_port = '0;
   logic [VCI_W-1:0]  pkt_in_vci = '0;
   logic              fwd_valid, fwd_miss;
   logic [PORT_W-1:0] fwd_port;
   logic [VCI_W-1:0]  fwd_vci;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural model: key {port,vci} -> result {port,vci}
   int   model[int];
   logic exp_valid = 1'b0, exp_miss = 1'b0, exp_err = 1'b0;
   int   exp_res = 0;

   always #5 clk = ~clk;

   vcx_label_swap #(.PORT_W(PORT_W), .VCI_W(VCI_W), .DEPTH(DEPTH)) u_vcx_label_swap (
      .clk, .rst_n, .cfg_valid, .cfg_op, .cfg_in_port, .cfg_in_vci,
      .cfg_out_port, .cfg_out_vci, .cfg_err, .pkt_valid, .pkt_in_port,
      .pkt_in_vci, .fwd_valid, .fwd_miss, .fwd_port, .fwd_vci
   );

   always @(posedge clk) begin
      int pk, ck;
      cycles++;
      if (!rst_n) begin
         model.delete();
         exp_valid = 1'b0; exp_miss = 1'b0; exp_err = 1'b0; exp_res = 0;
      end else begin
         pk = {pkt_in_port, pkt_in_vci};
         ck = {cfg_in_port, cfg_in_vci};
         exp_valid = pkt_valid;
         exp_miss  = pkt_valid && !model.exists(pk);
         exp_res   = (pkt_valid && model.exists(pk)) ? model[pk] : 0;
         exp_err   = cfg_valid && !cfg_op && !model.exists(ck) && model.num() >= DEPTH;
         if (cfg_valid && !cfg_op && !exp_err) model[ck] = {cfg_out_port, cfg_out_vci};
         if (cfg_valid && cfg_op && model.exists(ck)) model.delete(ck);
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (fwd_valid !== exp_valid || fwd_miss !== exp_miss || cfg_err !== exp_err ||
             {fwd_port, fwd_vci} !== exp_res[PORT_W+VCI_W-1:0]) begin
            errors++;
            $display("FAIL %s t=%0t actual v=%b m=%b e=%b res=%h expected v=%b m=%b e=%b res=%h",
                     cur_req, $time, fwd_valid, fwd_miss, cfg_err, {fwd_port, fwd_vci},
                     exp_valid, exp_miss, exp_err, exp_res[PORT_W+VCI_W-1:0]);
         end
      end
   end

   always @(posedge clk) begin
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step(input bit cv, input bit op, input int ip, input int iv,
                       input int op_p, input int ov, input bit pv, input int pp, input int pvci);
      @(negedge clk);
      cfg_valid = cv; cfg_op = op;
      cfg_in_port = ip[PORT_W-1:0]; cfg_in_vci = iv[VCI_W-1:0];
      cfg_out_port = op_p[PORT_W-1:0]; cfg_out_vci = ov[VCI_W-1:0];
      pkt_valid = pv; pkt_in_port = pp[PORT_W-1:0]; pkt_in_vci = pvci[VCI_W-1:0];
   endtask

   task automatic setup(input int ip, input int iv, input int op_p, input int ov);
      step(1, 0, ip, iv, op_p, ov, 0, 0, 0);
   endtask
   task automatic tear(input int ip, input int iv);
      step(1, 1, ip, iv, 0, 0, 0, 0, 0);
   endtask
   task automatic pkt(input int pp, input int pv);
      step(0, 0, 0, 0, 0, 0, 1, pp, pv);
   endtask
   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(); pkt(1, 1); pkt(0, 0); idle();

      cur_req = "R3";
      setup(1, 1, 3, 1);
      setup(2, 1, 3, 2);
      cur_req = "R2";
      pkt(1, 1); pkt(2, 1); idle();
      cur_req = "R4";
      pkt(0, 1); pkt(1, 2); idle();

      cur_req = "R5";
      setup(1, 1, 2, 9);
      pkt(1, 1); pkt(2, 1); idle();

      cur_req = "R6";
      tear(2, 1);
      pkt(2, 1); pkt(1, 1);
      tear(0, 5);
      pkt(1, 1); idle();

      cur_req = "R9";
      step(1, 0, 0, 7, 1, 4, 1, 0, 7);
      pkt(0, 7);
      step(1, 1, 0, 7, 0, 0, 1, 0, 7);
      pkt(0, 7); idle();

      cur_req = "R8";
      for (int i = 0; model.num() < DEPTH && i < 64; i++) setup(i % 4, 8 + i / 4, 3 - i % 4, i);
      for (int i = 0; i < 16; i++) pkt(i % 4, 8 + i / 4);
      pkt(1, 1);

      cur_req = "R7";
      setup(3, 15, 1, 1);
      idle();
      pkt(3, 15);
      cur_req = "R5";
      setup(1, 1, 0, 14);
      pkt(1, 1);
      cur_req = "R8";
      tear(0, 8);
      setup(3, 15, 2, 2);
      pkt(3, 15); pkt(0, 8); idle();

      cur_req = "R2";
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 3);
         step(r != 0, $urandom_range(0, 2) == 0, $urandom_range(0, 3), $urandom_range(0, 5),
              $urandom_range(0, 3), $urandom_range(0, 15), r != 1,
              $urandom_range(0, 3), $urandom_range(0, 5));
      end
      idle(); idle();

      cur_req = "R1";
      @(negedge clk); rst_n = 1'b0;
      idle(); idle();
      rst_n = 1'b1;
      pkt(1, 1); idle(); idle();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule